// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Register

This block holds the normal-event status flags of an SD card host controller. It watches the controller's present-state levels: card present, buffer readable, buffer writable, data line busy, read transfer active and write transfer active. It also takes one-cycle event strobes from the command, data and DMA engines. From these it sets seven sticky flags, each on its own edge or qualified strobe.

A flag can only set while its status-enable bit is 1. Software clears a flag by writing 1 to its position. The block also drives a single active-high interrupt line, registered, built from the flags masked by a separate signal-enable vector. A DMA error does not set the DMA-done flag. Instead it raises a one-cycle fault strobe toward the error-status logic, which sits outside this block.

The present-state inputs must already be synchronous to `clk`. Edge detection compares each level with a copy of itself delayed by one clock.

Top module: `sdh_irq_status`

## Requirements
- R1: While `rst_n` is low, and after it is released, `status`, `irq` and `dma_fault` are all 0 until an event occurs.
- R2: `status[6]` (card inserted) sets on a 0-to-1 change of `card_present`. A card that stays present does not set the flag again after it has been cleared.
- R3: `status[5]` (read ready) sets on a 0-to-1 change of `rd_buf_en`, and `status[4]` (write ready) sets on a 0-to-1 change of `wr_buf_en`. A 1-to-0 change of either sets nothing.
- R4: `status[3]` (DMA done) sets on `dma_done_ok` only when `dma_done_err` is low in the same cycle. `dma_done_err` leaves `status[3]` clear and drives `dma_fault` high for the following cycle.
- R5: `status[2]` (block gap) sets only while `gap_stop_req` is 1. With `xfer_is_write`=1 it sets on a 1-to-0 change of `wr_xfer_act`, and with `xfer_is_write`=0 on a 1-to-0 change of `dat_line_act`.
- R6: `status[1]` (transfer complete) sets with `xfer_is_write`=1 on a 1-to-0 change of `dat_line_act`, and with `xfer_is_write`=0 on a 1-to-0 change of `rd_xfer_act`, whatever the value of `gap_stop_req`.
- R7: `status[0]` (command complete) sets on `cmd_resp_end`. It does not set when `cmd_is_auto12` or `cmd_timeout` is high in the same cycle.
- R8: A flag whose `stat_en` bit is 0 at the event cycle does not set. Enabling it later does not set it retroactively.
- R9: A cycle with `clr_we`=1 clears each flag whose `clr_data` bit is 1 and leaves flags with a 0 bit untouched. A set event in the same cycle as a clear of that flag leaves the flag at 1.
- R10: `irq` is 1 in the cycle after any bit of `status & sig_en` is 1, and 0 in the cycle after that AND is all zero.
- R11: Every status flag updates at the clock edge where its qualifying edge or strobe is first seen, so it reads as 1 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| card_present | input | 1 | Card inserted level |
| rd_buf_en | input | 1 | Buffer holds data ready to read |
| wr_buf_en | input | 1 | Buffer has room to write |
| dat_line_act | input | 1 | Data line busy level |
| rd_xfer_act | input | 1 | Read transfer in progress |
| wr_xfer_act | input | 1 | Write transfer in progress |
| xfer_is_write | input | 1 | Direction of the current transfer, 1 = write |
| gap_stop_req | input | 1 | Stop-at-block-gap request control bit |
| cmd_resp_end | input | 1 | Strobe: response end bit received |
| cmd_is_auto12 | input | 1 | Qualifier: the response belongs to an automatic stop command |
| cmd_timeout | input | 1 | Strobe: command timeout error |
| dma_done_ok | input | 1 | Strobe: DMA engine finished |
| dma_done_err | input | 1 | Strobe: DMA engine reported an error |
| stat_en | input | 7 | Per-flag status enable |
| sig_en | input | 7 | Per-flag interrupt signal enable |
| clr_we | input | 1 | Write strobe for clear-by-one |
| clr_data | input | 7 | Clear mask, 1 clears a flag |
| status | output | 7 | Sticky status flags |
| irq | output | 1 | Combined interrupt, registered, active high |
| dma_fault | output | 1 | One-cycle strobe after a DMA error |

## Verification
A vector table walks each present-state level through rising and falling changes in both transfer directions, with the block-gap request both on and off. This separates the flags driven by a rising edge from those driven by a falling edge, and it shows which falling edge feeds transfer complete and which feeds block gap in each direction. Command and DMA strobes are applied alone and together with their suppressing companions (timeout, auto stop, error), which shows that the qualifiers win. Directed sequences then apply status-enable gating, clears with mixed masks, a set and a clear in the same cycle, and signal-enable masking. They also check the one-cycle lag of `irq` behind the flags.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
   // flag positions: neighbours decode these
   localparam int unsigned STAT_W    = 7;
   localparam int unsigned BIT_CMD   = 0;
   localparam int unsigned BIT_XFER  = 1;
   localparam int unsigned BIT_GAP   = 2;
   localparam int unsigned BIT_DMA   = 3;
   localparam int unsigned BIT_WRRDY = 4;
   localparam int unsigned BIT_RDRDY = 5;
   localparam int unsigned BIT_CARD  = 6;

   // rising-edge level group
   localparam int unsigned RISE_W    = 3;
   localparam int unsigned RI_CARD   = 0;
   localparam int unsigned RI_RD     = 1;
   localparam int unsigned RI_WR     = 2;

   // falling-edge level group
   localparam int unsigned FALL_W    = 3;
   localparam int unsigned FI_BUSY   = 0;
   localparam int unsigned FI_RDACT  = 1;
   localparam int unsigned FI_WRACT  = 2;
endpackage

// File: rtl/sdh_irq_edge.sv
module sdh_irq_edge #(
   parameter int unsigned W           = 3,
   parameter bit          DETECT_RISE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] edge_o
);
   if (W < 1) begin : g_bad_w
      $error("sdh_irq_edge: W must be at least 1");
   end

   logic [W-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_i;
   end

   if (DETECT_RISE) begin : g_rise
      assign edge_o = lvl_i & ~lvl_q;
   end else begin : g_fall
      assign edge_o = ~lvl_i & lvl_q;
   end
endmodule

// File: rtl/sdh_irq_events.sv
module sdh_irq_events
   import sdh_irq_pkg::*;
(
   input  logic              [RISE_W-1:0] rise_i,
   input  logic              [FALL_W-1:0] fall_i,
   input  logic                           is_write_i,
   input  logic                           gap_req_i,
   input  logic                           cmd_end_i,
   input  logic                           cmd_auto_i,
   input  logic                           cmd_tmo_i,
   input  logic                           dma_ok_i,
   input  logic                           dma_err_i,
   output logic              [STAT_W-1:0] set_req_o
);
   logic gap_edge;
   logic done_edge;

   always_comb begin
      gap_edge  = is_write_i ? fall_i[FI_WRACT] : fall_i[FI_BUSY];
      done_edge = is_write_i ? fall_i[FI_BUSY]  : fall_i[FI_RDACT];

      set_req_o            = '0;
      set_req_o[BIT_CMD]   = cmd_end_i & ~cmd_auto_i & ~cmd_tmo_i;
      set_req_o[BIT_XFER]  = done_edge;
      set_req_o[BIT_GAP]   = gap_req_i & gap_edge;
      set_req_o[BIT_DMA]   = dma_ok_i & ~dma_err_i;
      set_req_o[BIT_WRRDY] = rise_i[RI_WR];
      set_req_o[BIT_RDRDY] = rise_i[RI_RD];
      set_req_o[BIT_CARD]  = rise_i[RI_CARD];
   end
endmodule

// File: rtl/sdh_irq_sticky.sv
module sdh_irq_sticky #(
   parameter int unsigned W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_req_i,
   input  logic [W-1:0] en_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_mask_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("sdh_irq_sticky: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic hit;
      logic wipe;
      logic q;

      assign hit  = set_req_i[i] & en_i[i];
      assign wipe = clr_we_i & clr_mask_i[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= 1'b0;
         else if (hit)  q <= 1'b1;
         else if (wipe) q <= 1'b0;
      end

      assign q_o[i] = q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (set_req_i[i] && en_i[i]) |=> q_o[i]);                       // R9
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we_i && clr_mask_i[i] && !set_req_i[i]) |=> !q_o[i]);   // R9
      AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (q_o[i] && !(clr_we_i && clr_mask_i[i])) |=> q_o[i]);        // R9
      AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
         (!q_o[i] && !en_i[i]) |=> !q_o[i]);                           // R8
   end
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
   import sdh_irq_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              card_present,
   input  logic              rd_buf_en,
   input  logic              wr_buf_en,
   input  logic              dat_line_act,
   input  logic              rd_xfer_act,
   input  logic              wr_xfer_act,
   input  logic              xfer_is_write,
   input  logic              gap_stop_req,
   input  logic              cmd_resp_end,
   input  logic              cmd_is_auto12,
   input  logic              cmd_timeout,
   input  logic              dma_done_ok,
   input  logic              dma_done_err,
   input  logic [STAT_W-1:0] stat_en,
   input  logic [STAT_W-1:0] sig_en,
   input  logic              clr_we,
   input  logic [STAT_W-1:0] clr_data,
   output logic [STAT_W-1:0] status,
   output logic              irq,
   output logic              dma_fault
);
   if (BIT_CARD != STAT_W - 1) begin : g_bad_map
      $error("sdh_irq_status: card flag must be the top status bit");
   end

   logic [RISE_W-1:0] rise_lvl, rise_evt;
   logic [FALL_W-1:0] fall_lvl, fall_evt;
   logic [STAT_W-1:0] set_req;
   logic              fault_q;

   always_comb begin
      rise_lvl           = '0;
      rise_lvl[RI_CARD]  = card_present;
      rise_lvl[RI_RD]    = rd_buf_en;
      rise_lvl[RI_WR]    = wr_buf_en;
      fall_lvl           = '0;
      fall_lvl[FI_BUSY]  = dat_line_act;
      fall_lvl[FI_RDACT] = rd_xfer_act;
      fall_lvl[FI_WRACT] = wr_xfer_act;
   end

   sdh_irq_edge #(.W(RISE_W), .DETECT_RISE(1'b1)) u_rise (
      .clk(clk), .rst_n(rst_n), .lvl_i(rise_lvl), .edge_o(rise_evt));

   sdh_irq_edge #(.W(FALL_W), .DETECT_RISE(1'b0)) u_fall (
      .clk(clk), .rst_n(rst_n), .lvl_i(fall_lvl), .edge_o(fall_evt));

   sdh_irq_events u_events (
      .rise_i(rise_evt), .fall_i(fall_evt),
      .is_write_i(xfer_is_write), .gap_req_i(gap_stop_req),
      .cmd_end_i(cmd_resp_end), .cmd_auto_i(cmd_is_auto12), .cmd_tmo_i(cmd_timeout),
      .dma_ok_i(dma_done_ok), .dma_err_i(dma_done_err),
      .set_req_o(set_req));

   sdh_irq_sticky #(.W(STAT_W)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_req_i(set_req), .en_i(stat_en),
      .clr_we_i(clr_we), .clr_mask_i(clr_data), .q_o(status));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= dma_done_err;
   end
   assign dma_fault = fault_q;

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(status & sig_en);
      end
      assign irq = irq_q;

      AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
         (|(status & sig_en)) |=> irq);                          // R10
      AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
         !(|(status & sig_en)) |=> !irq);                        // R10
   end else begin : g_irq_comb
      assign irq = |(status & sig_en);
   end

   AST_TMO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_timeout && !status[BIT_CMD] && !cmd_resp_end) |=> !status[BIT_CMD]);   // R7
   AST_TMO_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_resp_end && cmd_timeout && !status[BIT_CMD]) |=> !status[BIT_CMD]);    // R7
   AST_AUTO12_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_resp_end && cmd_is_auto12 && !status[BIT_CMD]) |=> !status[BIT_CMD]);  // R7
   AST_DMA_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done_err && !status[BIT_DMA]) |=> !status[BIT_DMA]);                   // R4
   AST_DMA_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      dma_done_err |=> dma_fault);                                                // R4
   AST_GAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!gap_stop_req && !status[BIT_GAP]) |=> !status[BIT_GAP]);                  // R5
   AST_CARD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (card_present && stat_en[BIT_CARD] && !$past(card_present)) |=> status[BIT_CARD]); // R2
endmodule

// File: tb/sdh_irq_status_bench.sv
`timescale 1ns/1ps
module sdh_irq_status_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       card_present = 0, rd_buf_en = 0, wr_buf_en = 0;
   logic       dat_line_act = 0, rd_xfer_act = 0, wr_xfer_act = 0;
   logic       xfer_is_write = 0, gap_stop_req = 0;
   logic       cmd_resp_end = 0, cmd_is_auto12 = 0, cmd_timeout = 0;
   logic       dma_done_ok = 0, dma_done_err = 0;
   logic [6:0] stat_en = 7'h7f, sig_en = 7'h00, clr_data = 7'h00;
   logic       clr_we = 0;
   logic [6:0] status;
   logic       irq, dma_fault;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   sdh_irq_status u_sdh_irq_status (
      .clk(clk), .rst_n(rst_n), .card_present(card_present), .rd_buf_en(rd_buf_en),
      .wr_buf_en(wr_buf_en), .dat_line_act(dat_line_act), .rd_xfer_act(rd_xfer_act),
      .wr_xfer_act(wr_xfer_act), .xfer_is_write(xfer_is_write), .gap_stop_req(gap_stop_req),
      .cmd_resp_end(cmd_resp_end), .cmd_is_auto12(cmd_is_auto12), .cmd_timeout(cmd_timeout),
      .dma_done_ok(dma_done_ok), .dma_done_err(dma_done_err), .stat_en(stat_en),
      .sig_en(sig_en), .clr_we(clr_we), .clr_data(clr_data), .status(status),
      .irq(irq), .dma_fault(dma_fault));

   // {pre[5:0], post[5:0], gap, write, {cmd,auto,tmo,ok,err}, expected}
   // level order: [0]card [1]rd_en [2]wr_en [3]busy [4]rd_act [5]wr_act
   localparam int NV = 17;
   localparam logic [25:0] VEC [NV] = '{
      {6'b000000, 6'b000001, 1'b0, 1'b0, 5'b00000, 7'h40},  // R2 card rise
      {6'b000000, 6'b000010, 1'b0, 1'b0, 5'b00000, 7'h20},  // R3 read ready
      {6'b000000, 6'b000100, 1'b0, 1'b0, 5'b00000, 7'h10},  // R3 write ready
      {6'b000111, 6'b000000, 1'b0, 1'b0, 5'b00000, 7'h00},  // R3 falling levels set nothing
      {6'b001000, 6'b000000, 1'b0, 1'b1, 5'b00000, 7'h02},  // R6 write busy release
      {6'b001000, 6'b000000, 1'b1, 1'b1, 5'b00000, 7'h02},  // R6 write, gap on
      {6'b100000, 6'b000000, 1'b1, 1'b1, 5'b00000, 7'h04},  // R5 write gap
      {6'b100000, 6'b000000, 1'b0, 1'b1, 5'b00000, 7'h00},  // R5 write gap, not requested
      {6'b010000, 6'b000000, 1'b0, 1'b0, 5'b00000, 7'h02},  // R6 read done
      {6'b001000, 6'b000000, 1'b1, 1'b0, 5'b00000, 7'h04},  // R5 read gap
      {6'b001000, 6'b000000, 1'b0, 1'b0, 5'b00000, 7'h00},  // R5 read gap, not requested
      {6'b000000, 6'b000000, 1'b0, 1'b0, 5'b10000, 7'h01},  // R7 command complete
      {6'b000000, 6'b000000, 1'b0, 1'b0, 5'b11000, 7'h00},  // R7 auto stop skipped
      {6'b000000, 6'b000000, 1'b0, 1'b0, 5'b10100, 7'h00},  // R7 timeout wins
      {6'b000000, 6'b000000, 1'b0, 1'b0, 5'b00010, 7'h08},  // R4 dma ok
      {6'b000000, 6'b000000, 1'b0, 1'b0, 5'b00011, 7'h00},  // R4 dma error
      {6'b000000, 6'b000011, 1'b0, 1'b0, 5'b10000, 7'h61}   // R11 mixed same cycle
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic levels(logic [5:0] l);
      {wr_xfer_act, rd_xfer_act, dat_line_act, wr_buf_en, rd_buf_en, card_present} = l;
   endtask

   task automatic strobes(logic [4:0] s);
      {cmd_resp_end, cmd_is_auto12, cmd_timeout, dma_done_ok, dma_done_err} = s;
   endtask

   task automatic clear_all();
      clr_we = 1; clr_data = 7'h7f; tick(); clr_we = 0; clr_data = 7'h00;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      chk("R1 status in reset", {25'd0, status}, 32'h0);
      chk("R1 irq in reset", {31'd0, irq}, 32'h0);
      repeat (2) @(negedge clk);
      rst_n = 1;
      tick();
      chk("R1 status after reset", {25'd0, status}, 32'h0);
      chk("R1 irq after reset", {31'd0, irq}, 32'h0);
      chk("R1 dma_fault after reset", {31'd0, dma_fault}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         v = VEC[i];
         gap_stop_req = v[13]; xfer_is_write = v[12];
         levels(v[25:20]);
         tick(); tick();
         clear_all();
         levels(v[19:14]);
         strobes(v[11:7]);
         tick();
         chk($sformatf("R11 vector %0d (R2-R7 table)", i), {25'd0, status}, {25'd0, v[6:0]});
         strobes(5'b0);
      end

      // R8: gating by status enable, no retroactive set
      levels(6'b0); gap_stop_req = 0; tick(); tick(); clear_all();
      stat_en = 7'h3f; card_present = 1; tick();
      chk("R8 card edge with enable off", {25'd0, status}, 32'h0);
      stat_en = 7'h7f; tick(); tick();
      chk("R8 no retroactive set", {25'd0, status}, 32'h0);

      // R2: steady card does not set again after clear
      card_present = 0; tick(); card_present = 1; tick();
      chk("R2 card rise", {31'd0, status[6]}, 32'h1);
      clear_all(); tick(); tick();
      chk("R2 steady card stays cleared", {31'd0, status[6]}, 32'h0);

      // R9: clear semantics
      cmd_resp_end = 1; rd_buf_en = 1; tick(); cmd_resp_end = 0;
      chk("R9 setup", {25'd0, status}, 32'h21);
      clr_we = 1; clr_data = 7'h00; tick(); clr_we = 0;
      chk("R9 write zero no effect", {25'd0, status}, 32'h21);
      clr_we = 1; clr_data = 7'h01; tick(); clr_we = 0;
      chk("R9 clear one bit", {25'd0, status}, 32'h20);
      clr_we = 1; clr_data = 7'h01; cmd_resp_end = 1; tick();
      clr_we = 0; cmd_resp_end = 0; clr_data = 7'h00;
      chk("R9 set wins over clear", {25'd0, status}, 32'h21);

      // R10: interrupt masking and latency
      tick();
      chk("R10 no signal enable", {31'd0, irq}, 32'h0);
      sig_en = 7'h01; tick();
      chk("R10 enabled flag drives irq", {31'd0, irq}, 32'h1);
      sig_en = 7'h02; tick();
      chk("R10 masked flags", {31'd0, irq}, 32'h0);
      sig_en = 7'h01; clear_all(); tick();
      chk("R10 cleared flags", {31'd0, irq}, 32'h0);
      cmd_resp_end = 1; tick(); cmd_resp_end = 0;
      chk("R10 flag set, irq not yet", {31'd0, irq}, 32'h0);
      chk("R11 flag visible next cycle", {31'd0, status[0]}, 32'h1);
      tick();
      chk("R10 irq one cycle later", {31'd0, irq}, 32'h1);

      // R4: DMA error strobe
      clear_all();
      dma_done_ok = 1; dma_done_err = 1; tick(); dma_done_ok = 0; dma_done_err = 0;
      chk("R4 fault strobe", {31'd0, dma_fault}, 32'h1);
      chk("R4 done stays clear", {31'd0, status[3]}, 32'h0);
      tick();
      chk("R4 fault ends", {31'd0, dma_fault}, 32'h0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule